// File: doc/BRIEF.md
# Banked-Stack 64-bit General Register File

This block holds the integer architectural registers of a 64-bit core: thirty-one general registers of 64 bits, read through two combinational ports and written through one clocked port. Every port is addressed by a 5-bit index. Index 31 names no general register. A per-port select input makes it stand for a hardwired zero or for the stack pointer.

There is one stack pointer for each of the four privilege levels. The current-level input picks the one that index 31 reaches. Each port can also work on a 32-bit view of a register. A narrow read returns the low word zero-extended. A narrow write stores the low word and clears the upper word. A read port can mark its operand as an address base. When that operand is a stack pointer that is not 16-byte aligned, the block raises an alignment fault. The program counter is not held here and no index reaches it.

Top module: `gpr_file_top`

## Requirements
- R1: With `wr_en` high, the register named by `wr_idx` (0 to 30) takes the formatted write data at the rising clock edge. Both read ports return the stored 64-bit value combinationally.
- R2: A read of an index that is written in the same cycle returns the value held before that clock edge. The new value appears after the edge.
- R3: A read port with its narrow input high returns bits [31:0] of the selected register in bits [31:0] and zeros in bits [63:32].
- R4: A write with `wr_narrow` high stores `wr_data[31:0]` in bits [31:0] and forces bits [63:32] of the target to zero.
- R5: Index 31 with the port's select input low (zero register) reads as 0 in both widths.
- R6: A write to index 31 with `wr_sp_sel` low changes no general register and no stack pointer.
- R7: Index 31 with the select input high reaches the stack pointer of the level on `cur_level` (0 to 3). A write at one level leaves the stack pointers of the other levels unchanged.
- R8: A narrow read of a stack pointer returns its low 32 bits zero-extended. A narrow write to a stack pointer clears its upper 32 bits.
- R9: `sp_align_fault` is high exactly when some read port has its address-base input high, index 31 and select high, and the selected stack pointer has nonzero bits [3:0].
- R10: Synchronous active-high `rst` clears all general registers and all four stack pointers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cur_level | input | 2 | Current privilege level, selects the stack pointer bank |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_sp_sel | input | 1 | Port A: index 31 means the stack pointer (1) or zero (0) |
| rd_a_narrow | input | 1 | Port A 32-bit view |
| rd_a_as_base | input | 1 | Port A operand is used as an address base |
| rd_a_data | output | 64 | Port A read data |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_sp_sel | input | 1 | Port B: index 31 means the stack pointer (1) or zero (0) |
| rd_b_narrow | input | 1 | Port B 32-bit view |
| rd_b_as_base | input | 1 | Port B operand is used as an address base |
| rd_b_data | output | 64 | Port B read data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index |
| wr_sp_sel | input | 1 | Write: index 31 means the stack pointer (1) or discard (0) |
| wr_narrow | input | 1 | 32-bit write, upper word cleared |
| wr_data | input | 64 | Write data |
| sp_align_fault | output | 1 | Misaligned stack pointer used as an address base |

## Verification
Four properties are checked on every cycle. The zero register reads as zero. A narrow read has a zero upper word. The fault output agrees with the aligned-ness of what a base-marked stack-pointer read returns. A write, whether to a general register or to the active stack pointer, comes back on the next cycle. Other behaviours need ordered scenarios and are left to the bench's stimulus: the old-value return when a read and a write meet in the same cycle, the isolation of the four stack-pointer banks from each other, discarded writes to the zero register, and the clearing effect of reset.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    parameter int XLEN       = 64;
    parameter int HALF       = XLEN / 2;
    parameter int NUM_GPR    = 31;
    parameter int IDX_W      = $clog2(NUM_GPR + 1);
    parameter int NUM_LVL    = 4;
    parameter int LVL_W      = $clog2(NUM_LVL);
    parameter int ALIGN_BITS = 4;
    parameter int NUM_RD     = 2;

    localparam logic [IDX_W-1:0] SPECIAL_IDX = IDX_W'(NUM_GPR);

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        idx_t  idx;
        logic  sp_sel;
        logic  narrow;
        logic  as_base;
    } rd_req_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        logic  sp_sel;
        logic  narrow;
        word_t data;
    } wr_req_t;

    function automatic word_t view_fmt(input word_t value, input logic narrow);
        return narrow ? {{HALF{1'b0}}, value[HALF-1:0]} : value;
    endfunction

    function automatic logic is_misaligned(input word_t value);
        return |value[ALIGN_BITS-1:0];
    endfunction
endpackage

// File: rtl/gpr_regs.sv
module gpr_regs
    import gpr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  widx,
    input  word_t wdata,
    output word_t q [NUM_GPR]
);
    for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= '0;
            else if (we && widx == IDX_W'(g))
                q[g] <= wdata;
        end
    end
endmodule

// File: rtl/gpr_sp_bank.sv
module gpr_sp_bank
    import gpr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  lvl_t  lvl,
    input  word_t wdata,
    output word_t sp_cur
);
    word_t sp_q [NUM_LVL];

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst)
                sp_q[l] <= '0;
            else if (we && lvl == LVL_W'(l))
                sp_q[l] <= wdata;
        end
    end

    assign sp_cur = sp_q[lvl];
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
(
    input  rd_req_t req,
    input  word_t   regs [NUM_GPR],
    input  word_t   sp_cur,
    output word_t   data,
    output logic    misalign
);
    word_t raw;
    logic  hits_sp;

    always_comb begin
        hits_sp = (req.idx == SPECIAL_IDX) && req.sp_sel;
        if (req.idx == SPECIAL_IDX)
            raw = req.sp_sel ? sp_cur : '0;
        else
            raw = regs[req.idx];
        data     = view_fmt(raw, req.narrow);
        misalign = hits_sp && req.as_base && is_misaligned(sp_cur);
    end
endmodule

// File: rtl/gpr_file_top.sv
module gpr_file_top
    import gpr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cur_level,
    input  logic [4:0]  rd_a_idx,
    input  logic        rd_a_sp_sel,
    input  logic        rd_a_narrow,
    input  logic        rd_a_as_base,
    output logic [63:0] rd_a_data,
    input  logic [4:0]  rd_b_idx,
    input  logic        rd_b_sp_sel,
    input  logic        rd_b_narrow,
    input  logic        rd_b_as_base,
    output logic [63:0] rd_b_data,
    input  logic        wr_en,
    input  logic [4:0]  wr_idx,
    input  logic        wr_sp_sel,
    input  logic        wr_narrow,
    input  logic [63:0] wr_data,
    output logic        sp_align_fault
);
    wr_req_t wr;
    rd_req_t rd_req   [NUM_RD];
    word_t   rd_data  [NUM_RD];
    logic    rd_fault [NUM_RD];
    word_t   regs_q   [NUM_GPR];
    word_t   sp_cur;
    word_t   wr_fmt;
    logic    we_gpr;
    logic    we_sp;

    always_comb begin
        wr        = '{en: wr_en, idx: wr_idx, sp_sel: wr_sp_sel,
                      narrow: wr_narrow, data: wr_data};
        rd_req[0] = '{idx: rd_a_idx, sp_sel: rd_a_sp_sel,
                      narrow: rd_a_narrow, as_base: rd_a_as_base};
        rd_req[1] = '{idx: rd_b_idx, sp_sel: rd_b_sp_sel,
                      narrow: rd_b_narrow, as_base: rd_b_as_base};
        wr_fmt    = view_fmt(wr.data, wr.narrow);
        we_gpr    = wr.en && (wr.idx != SPECIAL_IDX);
        we_sp     = wr.en && (wr.idx == SPECIAL_IDX) && wr.sp_sel;
    end

    gpr_regs regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (we_gpr),
        .widx  (wr.idx),
        .wdata (wr_fmt),
        .q     (regs_q)
    );

    gpr_sp_bank sp_i (
        .clk    (clk),
        .rst    (rst),
        .we     (we_sp),
        .lvl    (cur_level),
        .wdata  (wr_fmt),
        .sp_cur (sp_cur)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        gpr_read_port port_i (
            .req      (rd_req[p]),
            .regs     (regs_q),
            .sp_cur   (sp_cur),
            .data     (rd_data[p]),
            .misalign (rd_fault[p])
        );
    end

    always_comb begin
        rd_a_data      = rd_data[0];
        rd_b_data      = rd_data[1];
        sp_align_fault = 1'b0;
        for (int p = 0; p < NUM_RD; p++)
            sp_align_fault = sp_align_fault | rd_fault[p];
    end
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cur_level,
    input logic [4:0]  rd_a_idx,
    input logic        rd_a_sp_sel,
    input logic        rd_a_narrow,
    input logic        rd_a_as_base,
    input logic [63:0] rd_a_data,
    input logic [4:0]  rd_b_idx,
    input logic        rd_b_sp_sel,
    input logic        rd_b_narrow,
    input logic        rd_b_as_base,
    input logic [63:0] rd_b_data,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic        wr_sp_sel,
    input logic        wr_narrow,
    input logic [63:0] wr_data,
    input logic        sp_align_fault
);
    logic a_sp_base, b_sp_base;
    assign a_sp_base = rd_a_as_base && rd_a_idx == 5'd31 && rd_a_sp_sel;
    assign b_sp_base = rd_b_as_base && rd_b_idx == 5'd31 && rd_b_sp_sel;

    a_r5_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == 5'd31 && !rd_a_sp_sel) |-> rd_a_data == 64'd0);

    a_r3_narrow_upper_clear: assert property (@(posedge clk) disable iff (rst)
        rd_b_narrow |-> rd_b_data[63:32] == 32'd0);

    a_r9_fault_on_misaligned_base: assert property (@(posedge clk) disable iff (rst)
        (a_sp_base && rd_a_data[3:0] != 4'd0) |-> sp_align_fault);

    a_r9_no_fault_without_base: assert property (@(posedge clk) disable iff (rst)
        (!a_sp_base && !b_sp_base) |-> !sp_align_fault);

    a_r4_narrow_write_visible: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && wr_idx != 5'd31 && wr_narrow && !rst)
         && rd_a_idx == $past(wr_idx) && !rd_a_narrow)
        |-> rd_a_data == {32'd0, $past(wr_data[31:0])});

    a_r7_sp_write_visible: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && wr_idx == 5'd31 && wr_sp_sel && !wr_narrow && !rst)
         && cur_level == $past(cur_level)
         && rd_b_idx == 5'd31 && rd_b_sp_sel && !rd_b_narrow)
        |-> rd_b_data == $past(wr_data));
endmodule

bind gpr_file_top gpr_file_chk chk_i (.*);

// File: tb/gpr_file_tb.sv
module gpr_file_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cur_level = '0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic        rd_a_sp_sel = 0, rd_a_narrow = 0, rd_a_as_base = 0;
    logic        rd_b_sp_sel = 0, rd_b_narrow = 0, rd_b_as_base = 0;
    logic        wr_en = 0, wr_sp_sel = 0, wr_narrow = 0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_a_data, rd_b_data;
    logic        sp_align_fault;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    gpr_file_top dut_i (.*);

    typedef struct packed {
        logic [4:0]  idx;
        logic        sp;
        logic        narrow;
        logic [63:0] wdata;
        logic [63:0] rexp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{5'd5,  1'b0, 1'b0, 64'h1122334455667788, 64'h1122334455667788},
        '{5'd5,  1'b0, 1'b1, 64'hFFFFFFFFAABBCCDD, 64'h00000000AABBCCDD},
        '{5'd0,  1'b0, 1'b0, 64'hDEADBEEFCAFEF00D, 64'hDEADBEEFCAFEF00D},
        '{5'd30, 1'b0, 1'b0, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF},
        '{5'd31, 1'b1, 1'b0, 64'h0000000000001000, 64'h0000000000001000},
        '{5'd31, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000},
        '{5'd17, 1'b0, 1'b1, 64'h123456789ABCDEF0, 64'h000000009ABCDEF0},
        '{5'd31, 1'b1, 1'b1, 64'hFFFFFFFF87654320, 64'h0000000087654320}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_op(input logic [4:0] idx, input logic sp, input logic nar,
                         input logic [63:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = idx; wr_sp_sel = sp; wr_narrow = nar; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_a(input logic [4:0] idx, input logic sp, input logic nar,
                        input logic base);
        rd_a_idx = idx; rd_a_sp_sel = sp; rd_a_narrow = nar; rd_a_as_base = base;
        #1;
    endtask

    task automatic rd_b(input logic [4:0] idx, input logic sp, input logic nar,
                        input logic base);
        rd_b_idx = idx; rd_b_sp_sel = sp; rd_b_narrow = nar; rd_b_as_base = base;
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R10: reset state
        rd_a(5'd0, 0, 0, 0);  chk("R10 gpr0 after reset", rd_a_data, 64'd0);
        rd_a(5'd30, 0, 0, 0); chk("R10 gpr30 after reset", rd_a_data, 64'd0);
        for (int l = 0; l < 4; l++) begin
            cur_level = 2'(l);
            rd_a(5'd31, 1, 0, 0);
            chk("R10 sp bank after reset", rd_a_data, 64'd0);
        end
        cur_level = 2'd0;

        // R1 R4 R5 R7 R8: vector table, written then read back on port A
        for (int i = 0; i < NV; i++) begin
            wr_op(VECS[i].idx, VECS[i].sp, VECS[i].narrow, VECS[i].wdata);
            rd_a(VECS[i].idx, VECS[i].sp, 1'b0, 1'b0);
            chk("R1/R4/R5/R8 table readback", rd_a_data, VECS[i].rexp);
        end

        // R6: zero-register write left others untouched
        rd_b(5'd30, 0, 0, 0); chk("R6 gpr30 unchanged", rd_b_data, 64'h0123456789ABCDEF);
        rd_b(5'd31, 1, 0, 0); chk("R6 sp unchanged", rd_b_data, 64'h0000000087654320);
        rd_b(5'd31, 0, 1, 0); chk("R5 narrow zero reg", rd_b_data, 64'd0);

        // R3: narrow read view
        rd_b(5'd0, 0, 1, 0); chk("R3 narrow read", rd_b_data, 64'h00000000CAFEF00D);

        // R2: same-cycle read and write
        wr_op(5'd3, 0, 0, 64'hA);
        @(negedge clk);
        wr_en = 1; wr_idx = 5'd3; wr_sp_sel = 0; wr_narrow = 0; wr_data = 64'hB;
        rd_b(5'd3, 0, 0, 0); chk("R2 old value same cycle", rd_b_data, 64'hA);
        @(negedge clk);
        wr_en = 0;
        #1 chk("R2 new value next cycle", rd_b_data, 64'hB);

        // R7: banked stack pointers
        cur_level = 2'd1; wr_op(5'd31, 1, 0, 64'h2008);
        cur_level = 2'd2; wr_op(5'd31, 1, 0, 64'h3000);
        cur_level = 2'd0; rd_a(5'd31, 1, 0, 0); chk("R7 level0 kept", rd_a_data, 64'h87654320);
        cur_level = 2'd1; rd_a(5'd31, 1, 0, 0); chk("R7 level1", rd_a_data, 64'h2008);
        cur_level = 2'd2; rd_a(5'd31, 1, 0, 0); chk("R7 level2", rd_a_data, 64'h3000);
        cur_level = 2'd3; rd_a(5'd31, 1, 0, 0); chk("R7 level3 untouched", rd_a_data, 64'd0);

        // R8: narrow write to SP clears upper word
        wr_op(5'd31, 1, 1, 64'hABCD000012340000);
        rd_a(5'd31, 1, 0, 0); chk("R8 narrow sp write", rd_a_data, 64'h12340000);

        // R9: alignment fault
        cur_level = 2'd0; rd_a(5'd31, 1, 0, 1);
        chk("R9 aligned no fault", {63'd0, sp_align_fault}, 64'd0);
        cur_level = 2'd1; rd_a(5'd31, 1, 0, 1);
        chk("R9 misaligned base fault", {63'd0, sp_align_fault}, 64'd1);
        rd_a(5'd31, 1, 0, 0);
        chk("R9 not base no fault", {63'd0, sp_align_fault}, 64'd0);
        rd_a(5'd31, 0, 0, 1);
        chk("R9 zero reg no fault", {63'd0, sp_align_fault}, 64'd0);
        rd_b(5'd31, 1, 1, 1);
        chk("R9 port B fault", {63'd0, sp_align_fault}, 64'd1);
        rd_b(5'd0, 0, 0, 0);

        // R10: reset again clears contents
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd_a(5'd0, 0, 0, 0); chk("R10 gpr0 cleared", rd_a_data, 64'd0);
        rd_a(5'd31, 1, 0, 0); chk("R10 sp level1 cleared", rd_a_data, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule